// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Timer Registers

This bridge sits between an 8-bit CPU data bus and a small file of 16-bit timer registers: a running count, several compare values and a capture value. The CPU can only move one byte per access. The bridge keeps the two halves of every 16-bit transfer consistent by using a single 8-bit holding register, which all registers of the timer share.

On a write, the high byte is parked in the holding register first. The low-byte write then commits the parked byte and the new low byte together, in one cycle, on a one-hot write-enable bus. On a read, the low-byte read returns the live low byte and, on the same clock edge, snapshots the live high byte into the holding register. A later high-byte read returns that snapshot, so a counter that keeps running cannot tear the value. Registers flagged as bypass registers (the compare registers) are treated differently: their high byte is read live, and reading them never touches the holding register.

Read data is combinational from the address. The register file supplies the current register values on a flat input bus.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset the holding register is 0x00, so a high-byte read of a non-bypass register returns 0x00 before any other access.
- R2: A write to an odd address (address bit 0 = 1, register index in the upper bits) loads the written byte into the holding register and asserts no write enable.
- R3: A write to an even address asserts exactly the write enable of that register index in the same cycle, with write data {holding register, written byte}.
- R4: Read data at an even address is the live low byte of that register. When a read strobe without a write strobe hits the even address of a non-bypass register, the live high byte is copied into the holding register at that clock edge.
- R5: Read data at an odd address of a non-bypass register is the holding register, not the live high byte.
- R6: For registers whose bit in BYPASS_MASK is 1, read data at the odd address is the live high byte, and reads of either byte leave the holding register unchanged.
- R7: One holding register is shared by all registers. A high-byte write to a second register before the low-byte write of the first makes the first register receive the second high byte.
- R8: Addresses whose register index is NUM_REGS or above give read data 0x00, assert no write enable and leave the holding register unchanged.
- R9: When read and write strobes are asserted together, the write takes effect and no read capture occurs.
- R10: At most one write enable is asserted in any cycle, and none is asserted without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (4) | Byte address: bit 0 selects high byte, upper bits the register index |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write byte from CPU |
| rdata_o | output | 8 | Read byte to CPU, combinational from address |
| reg_q_i | input | 16*NUM_REGS | Current register values, register i at bits [16*i+15:16*i] |
| reg_we_o | output | NUM_REGS | One-hot write enable to the register file |
| reg_wdata_o | output | 16 | 16-bit value to commit |

## Verification
The bench builds the block with its defaults: five registers, with indices 1 to 3 marked as bypass registers in BYPASS_MASK (5'b01110). This places captured and bypassed registers side by side, and the three-bit index leaves indices 5 to 7 as out-of-range addresses. The bench acts as the register file itself and commits each value that the bridge emits. Its model can therefore change live values between a low-byte read and a high-byte read, and it can interleave high-byte writes to different registers, so that snapshots and the sharing of the holding register become visible at the read port.

// File: rtl/wrb_pkg.sv
`timescale 1ns/1ps
package wrb_pkg;
  typedef logic [7:0] byte_t;

  // decoded access effect on the holding register and register file
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_WR_HI  = 2'd1,
    ACC_WR_LO  = 2'd2,
    ACC_RD_CAP = 2'd3
  } acc_e;
endpackage

// File: rtl/wrb_decode.sv
`timescale 1ns/1ps
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int NUM_REGS    = 5,
  parameter int IDX_W       = 3,
  parameter int ADDR_W      = IDX_W + 1,
  parameter logic [NUM_REGS-1:0] BYPASS_MASK = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hi_o,
  output logic              valid_o,
  output logic              bypass_o,
  output acc_e              kind_o
);
  localparam int NSLOT = 1 << IDX_W;

  logic [NSLOT-1:0] byp_pad;

  for (genvar g = 0; g < NSLOT; g++) begin : g_byp
    if (g < NUM_REGS) begin : g_real
      assign byp_pad[g] = BYPASS_MASK[g];
    end else begin : g_pad
      assign byp_pad[g] = 1'b0;
    end
  end

  assign idx_o    = addr_i[ADDR_W-1:1];
  assign hi_o     = addr_i[0];
  assign valid_o  = {1'b0, idx_o} < (IDX_W+1)'(NUM_REGS);
  assign bypass_o = byp_pad[idx_o];

  always_comb begin
    kind_o = ACC_NONE;
    if (valid_o) begin
      if (wr_i)                              kind_o = hi_o ? ACC_WR_HI : ACC_WR_LO;
      else if (rd_i && !hi_o && !bypass_o)   kind_o = ACC_RD_CAP;
    end
  end
endmodule

// File: rtl/wrb_hold.sv
`timescale 1ns/1ps
module wrb_hold
  import wrb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  acc_e  kind_i,
  input  byte_t wdata_i,
  input  byte_t live_hi_i,
  output byte_t hold_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q_o <= '0;
    end else begin
      unique case (kind_i)
        ACC_WR_HI:  hold_q_o <= wdata_i;
        ACC_RD_CAP: hold_q_o <= live_hi_i;
        default:    hold_q_o <= hold_q_o;
      endcase
    end
  end
endmodule

// File: rtl/wrb_rd_mux.sv
`timescale 1ns/1ps
module wrb_rd_mux
  import wrb_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter int IDX_W    = 3
) (
  input  logic [16*NUM_REGS-1:0] reg_q_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic                   hi_i,
  input  logic                   valid_i,
  input  logic                   bypass_i,
  input  byte_t                  hold_i,
  output byte_t                  live_hi_o,
  output byte_t                  rdata_o
);
  localparam int NSLOT = 1 << IDX_W;

  logic [15:0] slot [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < NUM_REGS) begin : g_real
      assign slot[g] = reg_q_i[16*g +: 16];
    end else begin : g_pad
      assign slot[g] = '0;
    end
  end

  assign live_hi_o = slot[idx_i][15:8];

  always_comb begin
    if (!valid_i)      rdata_o = '0;
    else if (!hi_i)    rdata_o = slot[idx_i][7:0];
    else if (bypass_i) rdata_o = live_hi_o;
    else               rdata_o = hold_i;
  end
endmodule

// File: rtl/wide_reg_bridge.sv
`timescale 1ns/1ps
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int NUM_REGS = 5,
  parameter logic [NUM_REGS-1:0] BYPASS_MASK = 5'b01110,
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [16*NUM_REGS-1:0] reg_q_i,
  output logic [NUM_REGS-1:0]    reg_we_o,
  output logic [15:0]            reg_wdata_o
);
  logic [IDX_W-1:0] idx;
  logic             hi, valid, bypass;
  acc_e             kind;
  byte_t            hold_q, live_hi;

  wrb_decode #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BYPASS_MASK(BYPASS_MASK)
  ) u_decode (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .idx_o(idx), .hi_o(hi), .valid_o(valid), .bypass_o(bypass), .kind_o(kind)
  );

  wrb_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .kind_i(kind),
    .wdata_i(wdata_i), .live_hi_i(live_hi), .hold_q_o(hold_q)
  );

  wrb_rd_mux #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd_mux (
    .reg_q_i(reg_q_i), .idx_i(idx), .hi_i(hi), .valid_i(valid),
    .bypass_i(bypass), .hold_i(hold_q), .live_hi_o(live_hi), .rdata_o(rdata_o)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
    assign reg_we_o[g] = (kind == ACC_WR_LO) && (idx == IDX_W'(g));
  end

  // low-byte write commits parked high byte in the same cycle
  assign reg_wdata_o = {hold_q, wdata_i};
endmodule

// File: rtl/wide_reg_bridge_chk.sv
`timescale 1ns/1ps
module wide_reg_bridge_chk #(
  parameter int NUM_REGS = 5,
  parameter logic [NUM_REGS-1:0] BYPASS_MASK = 5'b01110,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   rd_i,
  input logic                   wr_i,
  input logic [7:0]             wdata_i,
  input logic [7:0]             rdata_o,
  input logic [16*NUM_REGS-1:0] reg_q_i,
  input logic [NUM_REGS-1:0]    reg_we_o,
  input logic [15:0]            reg_wdata_o,
  input logic [7:0]             hold_q
);
  logic        c_valid, c_hi, c_byp;
  logic [15:0] c_sel;

  always_comb begin
    c_hi    = addr_i[0];
    c_valid = 1'b0;
    c_byp   = 1'b0;
    c_sel   = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i[ADDR_W-1:1] == IDX_W'(i)) begin
        c_valid = 1'b1;
        c_byp   = BYPASS_MASK[i];
        c_sel   = reg_q_i[16*i +: 16];
      end
    end
  end

  // R10
  we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_we_o) && (!wr_i -> reg_we_o == '0));

  // R8
  range_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_valid |-> (reg_we_o == '0 && rdata_o == 8'h00));

  // R2
  hi_wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && c_valid && c_hi) |=> hold_q == $past(wdata_i));

  // R3
  lo_wr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && c_valid && !c_hi) |-> (reg_we_o != '0 && reg_wdata_o == {hold_q, wdata_i}));

  // R4
  lo_rd_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && c_valid && !c_hi && !c_byp) |=> hold_q == $past(c_sel[15:8]));

  // R4
  lo_rd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_valid && !c_hi) |-> rdata_o == c_sel[7:0]);

  // R6
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_valid && wr_i && c_hi) && !(c_valid && rd_i && !wr_i && !c_hi && !c_byp)
    |=> $stable(hold_q));
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(
  .NUM_REGS(NUM_REGS), .BYPASS_MASK(BYPASS_MASK), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .reg_q_i(reg_q_i), .reg_we_o(reg_we_o),
  .reg_wdata_o(reg_wdata_o), .hold_q(hold_q)
);

// File: tb/wide_reg_bridge_tb.sv
`timescale 1ns/1ps
module wide_reg_bridge_tb;
  localparam int NR = 5;
  localparam logic [NR-1:0] BYP = 5'b01110;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [3:0]    addr_i = '0;
  logic          rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic [16*NR-1:0] reg_q_i;
  logic [NR-1:0] reg_we_o;
  logic [15:0]   reg_wdata_o;

  logic [15:0] regs [NR];
  logic [7:0]  m_hold;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  always_comb for (int i = 0; i < NR; i++) reg_q_i[16*i +: 16] = regs[i];

  wide_reg_bridge #(.NUM_REGS(NR), .BYPASS_MASK(BYP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .reg_q_i(reg_q_i),
    .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one bus cycle, compared against the behavioural model
  task automatic step(input int a, input bit rd, input bit wr, input logic [7:0] wd,
                      output logic [7:0] rdat);
    int idx; bit hi, ok_a, byp;
    logic [7:0] exp_rd; logic [NR-1:0] exp_we;
    logic [NR-1:0] got_we; logic [15:0] got_wd;
    string tag;
    idx = a >> 1; hi = a[0]; ok_a = idx < NR; byp = ok_a ? BYP[idx] : 1'b0;
    @(negedge clk_i);
    addr_i = 4'(a); rd_i = rd; wr_i = wr; wdata_i = wd;
    #1;
    if (!ok_a)     begin exp_rd = 8'h00; tag = "R8"; end
    else if (!hi)  begin exp_rd = regs[idx][7:0]; tag = "R4"; end
    else if (byp)  begin exp_rd = regs[idx][15:8]; tag = "R6"; end
    else           begin exp_rd = m_hold; tag = "R5"; end
    exp_we = (wr && ok_a && !hi) ? NR'(1 << idx) : '0;
    rdat = rdata_o; got_we = reg_we_o; got_wd = reg_wdata_o;
    chk(rdat == exp_rd, tag, rdat, exp_rd);
    chk(got_we == exp_we, (exp_we != 0) ? "R3" : "R10", got_we, exp_we);
    if (exp_we != 0) chk(got_wd == {m_hold, wd}, "R3", got_wd, {m_hold, wd});
    @(posedge clk_i);
    #1;
    for (int i = 0; i < NR; i++) if (got_we[i]) regs[i] = got_wd;
    if (ok_a && wr && hi)                  m_hold = wd;
    else if (ok_a && rd && !wr && !hi && !byp) m_hold = regs[idx][15:8];
    rd_i = 0; wr_i = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < NR; i++) regs[i] = 16'h0;
    m_hold = 8'h00;
    #2 rst_ni = 1'b0;
    #20 rst_ni = 1'b1;

    // R1: holding register cleared by reset
    step(1, 1, 0, 8'h00, r);   chk(r == 8'h00, "R1", r, 8'h00);

    // R2, R3: high then low write to register 0
    step(1, 0, 1, 8'hAB, r);
    step(0, 0, 1, 8'hCD, r);   chk(regs[0] == 16'hABCD, "R3", regs[0], 16'hABCD);

    // R4, R5: snapshot survives live change
    regs[0] = 16'h4455;
    step(0, 1, 0, 8'h00, r);   chk(r == 8'h55, "R4", r, 8'h55);
    regs[0] = 16'h1234;
    step(1, 1, 0, 8'h00, r);   chk(r == 8'h44, "R5", r, 8'h44);

    // R6: bypass register read live, hold untouched
    regs[1] = 16'h5678;
    step(2, 1, 0, 8'h00, r);   chk(r == 8'h78, "R6", r, 8'h78);
    step(3, 1, 0, 8'h00, r);   chk(r == 8'h56, "R6", r, 8'h56);
    step(1, 1, 0, 8'h00, r);   chk(r == 8'h44, "R6", r, 8'h44);

    // R7: interleaved high writes share one holding register
    step(1, 0, 1, 8'h11, r);
    step(5, 0, 1, 8'h22, r);
    step(0, 0, 1, 8'h33, r);   chk(regs[0] == 16'h2233, "R7", regs[0], 16'h2233);

    // R8: out-of-range write and read
    step(12, 0, 1, 8'h99, r);  chk(r == 8'h00, "R8", r, 8'h00);
    step(13, 1, 0, 8'h00, r);
    step(1, 1, 0, 8'h00, r);   chk(r == 8'h22, "R8", r, 8'h22);

    // R9: read and write together, write wins, no capture
    regs[4] = 16'hF0F0;
    step(8, 1, 1, 8'h5A, r);   chk(regs[4] == 16'h225A, "R9", regs[4], 16'h225A);
    step(1, 1, 0, 8'h00, r);   chk(r == 8'h22, "R9", r, 8'h22);

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 4) == 0) regs[$urandom_range(0, NR-1)] = 16'($urandom);
      step(int'($urandom_range(0, 15)), 1'($urandom), 1'($urandom), 8'($urandom), r);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule